// File: doc/BRIEF.md
# Floating-Point Exception Control and Status Register

This block keeps the two 16-bit words that govern exception handling in a floating-point datapath. The first is a control word whose low six bits mask individual exception kinds. The second is a status word that records sticky exception flags, a summary bit and four comparison condition bits. Arithmetic units report exception events as one-cycle pulses. Each event sets its flag. It is then resolved in one of two ways, chosen by its mask bit in the control word: handled by default in hardware, or raised to software as an interrupt request.

When an event arrives while its mask is set, the block emits a one-cycle default-handling pulse on `auto_o` for the unit that produces the fallback result. An unmasked flag drives the summary bit and `irq_o` for as long as it stays set and unmasked. A comparison unit writes the condition bits. The whole status word is always presented on `sw_o`, so a move into a general register can read it. An initialize command restores the power-on state, in which every exception is masked.

Top module: `fpcsr_top`

## Requirements
- R1: After synchronous reset, `cw_o` is 16'h037F, `sw_o` is 16'h0000, `irq_o` is 0 and `auto_o` is 0.
- R2: An event pulse on `exc_evt_i[k]` sets status flag `sw_o[k]` one cycle later. The bit order is invalid=0, denormal=1, divide-by-zero=2, overflow=3, underflow=4, precision=5. The flag stays set after the pulse ends.
- R3: If control bit `cw_o[k]` is 1 in the cycle an event on bit k arrives, `auto_o[k]` is 1 for exactly the following cycle. Otherwise `auto_o[k]` is 0.
- R4: The summary bit `sw_o[7]` is 1 whenever some status flag k is set while `cw_o[k]` is 0, and `irq_o` equals that bit. Both update in the same cycle as the flags.
- R5: A change to a mask bit re-evaluates the summary and `irq_o` against flags that are already set, with the same one-cycle timing as a control write.
- R6: `flag_clr_i` clears flags 5:0 and the summary one cycle later. An event in the same cycle still sets its flag. The condition bits are not changed.
- R7: `init_i` loads `cw_o` with 16'h037F and clears all flags, the summary, the condition bits and `auto_o` one cycle later. It overrides a control write, a condition write and events in the same cycle.
- R8: On `cc_wr_i`, `cc_i` = {C3,C2,C1,C0} is captured into `sw_o[14]`, `sw_o[10]`, `sw_o[9]` and `sw_o[8]` one cycle later. Otherwise those bits hold.
- R9: On `cw_wr_i` without `init_i`, `cw_o` takes `cw_wdata_i` one cycle later. Otherwise it holds.
- R10: Status bits 15, 13:11 and 6 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Initialize command |
| cw_wr_i | input | 1 | Control word write strobe |
| cw_wdata_i | input | 16 | Control word write data |
| exc_evt_i | input | 6 | Exception event pulses, one per kind |
| flag_clr_i | input | 1 | Clear exception flags |
| cc_wr_i | input | 1 | Condition bit write strobe |
| cc_i | input | 4 | Condition bits {C3,C2,C1,C0} |
| cw_o | output | 16 | Control word |
| sw_o | output | 16 | Status word |
| irq_o | output | 1 | Software exception request |
| auto_o | output | 6 | Default-handling pulses for masked events |

## Verification
The bench writes a new mask in the same cycle as an event. A design that picked the wrong mask would either skip the default-handling pulse or fire it for an event that is now unmasked. The bench also sends a flag clear together with a fresh event. A design with the wrong priority would lose that event and drop `irq_o` although an unmasked flag remains. It issues initialize together with writes and events, where a wrong priority leaves stale condition bits or an unmasked control word. Finally it unmasks and remasks flags that are already set, which exposes a summary that lags a cycle or is never re-evaluated.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int EXC_N  = 6;
  localparam int CC_N   = 4;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] CW_RESET = 16'h037F;

  localparam int SW_SUM_POS = 7;
  localparam int SW_C0_POS  = 8;
  localparam int SW_C1_POS  = 9;
  localparam int SW_C2_POS  = 10;
  localparam int SW_C3_POS  = 14;

  function automatic logic [WORD_W-1:0] pack_sw(
    input logic [EXC_N-1:0] flg,
    input logic             sum,
    input logic [CC_N-1:0]  cc
  );
    logic [WORD_W-1:0] w;
    w              = '0;
    w[EXC_N-1:0]   = flg;
    w[SW_SUM_POS]  = sum;
    w[SW_C0_POS]   = cc[0];
    w[SW_C1_POS]   = cc[1];
    w[SW_C2_POS]   = cc[2];
    w[SW_C3_POS]   = cc[3];
    return w;
  endfunction
endpackage

// File: rtl/fpcsr_ctrl_word.sv
module fpcsr_ctrl_word #(
  parameter int                WORD_W  = 16,
  parameter int                MASK_N  = 6,
  parameter logic [WORD_W-1:0] CW_INIT = 16'h037F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [MASK_N-1:0] mask_d_o,
  output logic [WORD_W-1:0] cw_q_o
);
  logic [WORD_W-1:0] cw_d;
  logic [WORD_W-1:0] cw_q;

  always_comb begin
    if (init_i)    cw_d = CW_INIT;
    else if (wr_i) cw_d = wdata_i;
    else           cw_d = cw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cw_q <= CW_INIT;
    else     cw_q <= cw_d;
  end

  assign mask_d_o = cw_d[MASK_N-1:0];
  assign cw_q_o   = cw_q;

  AST_INIT_LOADS_CW: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (cw_q_o == CW_INIT)); // R7
  AST_CW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !init_i) |=> (cw_q_o == $past(wdata_i))); // R9
  AST_CW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !init_i) |=> $stable(cw_q_o)); // R9
endmodule

// File: rtl/fpcsr_exc_flags.sv
module fpcsr_exc_flags #(
  parameter int EXC_N = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             clr_i,
  input  logic [EXC_N-1:0] evt_i,
  input  logic [EXC_N-1:0] mask_i,
  output logic [EXC_N-1:0] flg_d_o,
  output logic [EXC_N-1:0] flg_q_o,
  output logic [EXC_N-1:0] auto_o
);
  logic [EXC_N-1:0] flg_q;
  logic [EXC_N-1:0] auto_q;

  for (genvar k = 0; k < EXC_N; k++) begin : g_exc
    logic nxt;
    always_comb begin
      if (init_i) nxt = 1'b0;
      else        nxt = (flg_q[k] & ~clr_i) | evt_i[k];
    end
    assign flg_d_o[k] = nxt;

    always_ff @(posedge clk) begin
      if (rst) begin
        flg_q[k]  <= 1'b0;
        auto_q[k] <= 1'b0;
      end else begin
        flg_q[k]  <= nxt;
        auto_q[k] <= ~init_i & evt_i[k] & mask_i[k];
      end
    end
  end

  assign flg_q_o = flg_q;
  assign auto_o  = auto_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !clr_i) |=> ((flg_q & $past(flg_q)) == $past(flg_q))); // R2
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!init_i) |=> ((flg_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_AUTO_ONLY_MASKED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((auto_q & ~$past(mask_i)) == '0)); // R3
  AST_INIT_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (flg_q == '0 && auto_q == '0)); // R7
endmodule

// File: rtl/fpcsr_status_pack.sv
module fpcsr_status_pack
  import fpcsr_pkg::*;
#(
  parameter int FLAG_N = EXC_N,
  parameter int COND_N = CC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              cc_wr_i,
  input  logic [COND_N-1:0] cc_i,
  input  logic [FLAG_N-1:0] flg_d_i,
  input  logic [FLAG_N-1:0] flg_q_i,
  input  logic [FLAG_N-1:0] mask_d_i,
  output logic [WORD_W-1:0] sw_o,
  output logic              irq_o
);
  logic [COND_N-1:0] cc_q;
  logic [COND_N-1:0] cc_d;
  logic              sum_q;
  logic              sum_d;

  always_comb begin
    if (init_i)       cc_d = '0;
    else if (cc_wr_i) cc_d = cc_i;
    else              cc_d = cc_q;
  end

  assign sum_d = |(flg_d_i & ~mask_d_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q  <= '0;
      sum_q <= 1'b0;
    end else begin
      cc_q  <= cc_d;
      sum_q <= sum_d;
    end
  end

  assign sw_o  = pack_sw(flg_q_i, sum_q, cc_q);
  assign irq_o = sum_q;

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !cc_wr_i) |=> $stable(cc_q)); // R8
  AST_CC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (cc_wr_i && !init_i) |=> (cc_q == $past(cc_i))); // R8
  AST_INIT_CLEARS_CC: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (cc_q == '0 && !sum_q)); // R7
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              cw_wr_i,
  input  logic [WORD_W-1:0] cw_wdata_i,
  input  logic [EXC_N-1:0]  exc_evt_i,
  input  logic              flag_clr_i,
  input  logic              cc_wr_i,
  input  logic [CC_N-1:0]   cc_i,
  output logic [WORD_W-1:0] cw_o,
  output logic [WORD_W-1:0] sw_o,
  output logic              irq_o,
  output logic [EXC_N-1:0]  auto_o
);
  logic [EXC_N-1:0]  mask_d;
  logic [WORD_W-1:0] cw_q;
  logic [EXC_N-1:0]  flg_d;
  logic [EXC_N-1:0]  flg_q;

  fpcsr_ctrl_word #(
    .WORD_W (WORD_W),
    .MASK_N (EXC_N),
    .CW_INIT(CW_RESET)
  ) u_cw (
    .clk     (clk),
    .rst     (rst),
    .init_i  (init_i),
    .wr_i    (cw_wr_i),
    .wdata_i (cw_wdata_i),
    .mask_d_o(mask_d),
    .cw_q_o  (cw_q)
  );

  fpcsr_exc_flags #(
    .EXC_N(EXC_N)
  ) u_flags (
    .clk    (clk),
    .rst    (rst),
    .init_i (init_i),
    .clr_i  (flag_clr_i),
    .evt_i  (exc_evt_i),
    .mask_i (cw_q[EXC_N-1:0]),
    .flg_d_o(flg_d),
    .flg_q_o(flg_q),
    .auto_o (auto_o)
  );

  fpcsr_status_pack #(
    .FLAG_N(EXC_N),
    .COND_N(CC_N)
  ) u_sw (
    .clk     (clk),
    .rst     (rst),
    .init_i  (init_i),
    .cc_wr_i (cc_wr_i),
    .cc_i    (cc_i),
    .flg_d_i (flg_d),
    .flg_q_i (flg_q),
    .mask_d_i(mask_d),
    .sw_o    (sw_o),
    .irq_o   (irq_o)
  );

  assign cw_o = cw_q;

  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(flg_q & ~cw_q[EXC_N-1:0]))); // R4
  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sw_o[15] == 1'b0 && sw_o[13:11] == 3'b000 && sw_o[6] == 1'b0)); // R10
endmodule

// File: tb/fpcsr_top_tb_top.sv
`timescale 1ns/1ps
module fpcsr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_i = 1'b0;
  logic        cw_wr_i = 1'b0;
  logic [15:0] cw_wdata_i = '0;
  logic [5:0]  exc_evt_i = '0;
  logic        flag_clr_i = 1'b0;
  logic        cc_wr_i = 1'b0;
  logic [3:0]  cc_i = '0;
  logic [15:0] cw_o;
  logic [15:0] sw_o;
  logic        irq_o;
  logic [5:0]  auto_o;

  always #2 clk = ~clk;

  fpcsr_top dut_i (
    .clk(clk), .rst(rst), .init_i(init_i), .cw_wr_i(cw_wr_i),
    .cw_wdata_i(cw_wdata_i), .exc_evt_i(exc_evt_i), .flag_clr_i(flag_clr_i),
    .cc_wr_i(cc_wr_i), .cc_i(cc_i), .cw_o(cw_o), .sw_o(sw_o),
    .irq_o(irq_o), .auto_o(auto_o)
  );

  typedef struct {
    logic [15:0] cw;
    logic [15:0] sw;
    logic        irq;
    logic [5:0]  aut;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  logic [15:0] m_cw  = 16'h037F;
  logic [5:0]  m_flg = '0;
  logic [3:0]  m_cc  = '0;

  function automatic logic [15:0] model_sw(logic [5:0] f, logic [15:0] c, logic [3:0] k);
    logic [15:0] w;
    w = '0;
    w[5:0] = f;
    w[7]   = |(f & ~c[5:0]);
    w[8]   = k[0];
    w[9]   = k[1];
    w[10]  = k[2];
    w[14]  = k[3];
    return w;
  endfunction

  task automatic step(input logic ini, input logic wr, input logic [15:0] wd,
                      input logic [5:0] ev, input logic clr, input logic ccw,
                      input logic [3:0] cc, input string tag);
    exp_t e;
    logic [5:0] aut;
    @(negedge clk);
    init_i = ini; cw_wr_i = wr; cw_wdata_i = wd; exc_evt_i = ev;
    flag_clr_i = clr; cc_wr_i = ccw; cc_i = cc;
    if (ini) begin
      aut = '0; m_cw = 16'h037F; m_flg = '0; m_cc = '0;
    end else begin
      aut   = ev & m_cw[5:0];
      m_flg = (clr ? 6'h00 : m_flg) | ev;
      if (wr)  m_cw = wd;
      if (ccw) m_cc = cc;
    end
    e.cw  = m_cw;
    e.sw  = model_sw(m_flg, m_cw, m_cc);
    e.irq = e.sw[7];
    e.aut = aut;
    e.tag = tag;
    #1;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 16'h0, 6'h00, 1'b0, 1'b0, 4'h0, tag);
  endtask

  // Monitor: compares each expectation one clock after its inputs were applied
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (cw_o !== e.cw || sw_o !== e.sw || irq_o !== e.irq || auto_o !== e.aut) begin
        n_fail++;
        $display("FAIL %s: cw=%h sw=%h irq=%b auto=%h expected cw=%h sw=%h irq=%b auto=%h",
                 e.tag, cw_o, sw_o, irq_o, auto_o, e.cw, e.sw, e.irq, e.aut);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_vec++;
    if (cw_o !== 16'h037F || sw_o !== 16'h0 || irq_o !== 1'b0 || auto_o !== 6'h0) begin
      n_fail++;
      $display("FAIL R1: cw=%h sw=%h irq=%b auto=%h expected cw=037f sw=0000 irq=0 auto=00",
               cw_o, sw_o, irq_o, auto_o);
    end
    idle("R1 idle after reset");
    // R2 R3: masked invalid event sets bit0 and pulses auto
    step(0, 0, 16'h0, 6'b000001, 0, 0, 4'h0, "R2 R3 masked invalid");
    idle("R2 sticky flag, auto gone");
    // R9 R5: unmask invalid on a set flag
    step(0, 1, 16'h037E, 6'h00, 0, 0, 4'h0, "R9 R5 unmask raises irq");
    step(0, 1, 16'h037F, 6'h00, 0, 0, 4'h0, "R5 remask drops irq");
    // R4 R3: write all unmasked with divide-by-zero event same cycle (old mask applies to auto)
    step(0, 1, 16'h0000, 6'b000100, 0, 0, 4'h0, "R4 R3 same-cycle unmask");
    step(0, 0, 16'h0, 6'b001000, 0, 0, 4'h0, "R4 unmasked overflow");
    // R8 condition bits
    step(0, 0, 16'h0, 6'h00, 0, 1, 4'b1011, "R8 cc capture");
    idle("R8 cc hold");
    // R6 clear with precision event same cycle
    step(0, 0, 16'h0, 6'b100000, 1, 0, 4'h0, "R6 clear with event");
    step(0, 0, 16'h0, 6'h00, 1, 0, 4'h0, "R6 clear alone");
    // R10 all events, all unmasked, all cc
    step(0, 0, 16'h0, 6'h3F, 0, 1, 4'hF, "R10 unused bits zero");
    // R7 init overrides write, events and cc
    step(1, 1, 16'h0000, 6'h3F, 0, 1, 4'hA, "R7 init priority");
    idle("R7 after init");
    // R2 R3 R4: walk each exception with only that one unmasked, then others masked
    for (int k = 0; k < 6; k++) begin
      step(0, 1, 16'h037F & ~(16'h1 << k), 6'h00, 1, 0, 4'h0, "R5 prepare walk");
      step(0, 0, 16'h0, 6'h3F, 0, 0, 4'h0, "R2 R3 R4 walk");
      idle("R4 walk hold");
    end
    step(0, 1, 16'h1234, 6'h00, 0, 0, 4'h0, "R9 arbitrary write");
    step(1, 0, 16'h0, 6'h00, 0, 0, 4'h0, "R7 init restores");
    idle("R7 final");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule